// File: doc/BRIEF.md
# Two-Level MRU Victim Selector

This block holds the replacement state for the sets of a set-associative cache. The ways of each set are split into equal, contiguous groups. Per set it keeps one pointer to the group touched most recently, and per group one pointer to the way touched most recently inside it. It keeps no full recency order. A hit or a fill to a way moves both pointers to that way. The cache controller presents a set index and that set's per-way valid bits, and the block returns the way to evict.

When some way of the queried set is invalid, the lowest-numbered invalid way is returned. When every way is valid, the block makes two choices with a free-running LFSR inside it. It first picks one of the groups that is not the most recent group. It then picks, inside that group, one of the ways that is not that group's most recent way. Each random slice is reduced modulo the number of eligible candidates and then stepped over the excluded pointer, so a most-recent entry can never come out. The victim is combinational from the registered state, so the controller can read it and update in the same cycle.

Top module: `hnmru_repl_sel`

## Requirements
- R1: Way w belongs to group w / WPG and has in-group index w % WPG, with WPG = NUM_WAYS / NUM_GROUPS (default 16 ways in 2 groups of 8). The victim output carries the group in its upper bits and the in-group index in its lower bits.
- R2: After reset every group pointer and every in-group pointer is 0. With all ways valid, the first victims of any set therefore lie in ways 9 to 15.
- R3: A hit or fill (upd_valid_i) to way w of set s makes the group of w the most recent group of s, and makes w the most recent way of its group, both from the next clock edge.
- R4: With all ways valid, the victim never lies in the most recent group of the queried set.
- R5: With all ways valid, the victim is never the most recent way of its own group.
- R6: If any valid bit of the queried set is 0, the victim is the lowest-numbered invalid way, whatever the pointers hold. With all bits 0 it is way 0.
- R7: With the state unchanged and all ways valid, repeated queries return every one of the (NUM_GROUPS-1)*(WPG-1) eligible ways.
- R8: An update to one set leaves the pointers of every other set unchanged.
- R9: When an update and a query to the same set fall in the same cycle, the victim follows the state held before that update. The new state applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Hit or fill this cycle |
| upd_set_i | input | SET_W | Set of the hit or fill |
| upd_way_i | input | WAY_W | Way of the hit or fill |
| qry_set_i | input | SET_W | Set to pick a victim in |
| qry_valid_i | input | NUM_WAYS | Per-way valid bits of the queried set |
| victim_way_o | output | WAY_W | Way to evict |

## Verification
A recency update and a victim query can hit the same set in the same cycle. The query reads registers that the update writes only at the clock edge. The bench provokes this by driving an update and a query to one set together, where the update moves the recent group to the other half. It samples the victim before the edge and checks it against the old pointers, then samples after the edge and checks it against the new ones. Victims are judged against an eligible-way mask computed from the bench's own pointer model. The bench also collects, over many cycles, the set of victims it sees and compares it with that mask.

// File: rtl/hnmru_pkg.sv
package hnmru_pkg;
  function automatic int unsigned clog2_min1(int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/hnmru_lfsr.sv
module hnmru_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] state_q;

  // Galois form, shifts right
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= W'(1);
    else         state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
  end

  assign rnd_o = state_q;

  // R7
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/hnmru_mru_state.sv
module hnmru_mru_state #(
  parameter int NUM_SETS   = 4,
  parameter int NUM_GROUPS = 2,
  parameter int SET_W      = 2,
  parameter int GRP_W      = 1,
  parameter int WIG_W      = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 upd_valid_i,
  input  logic [SET_W-1:0]                     upd_set_i,
  input  logic [GRP_W-1:0]                     upd_grp_i,
  input  logic [WIG_W-1:0]                     upd_wig_i,
  input  logic [SET_W-1:0]                     rd_set_i,
  output logic [GRP_W-1:0]                     rd_grp_o,
  output logic [NUM_GROUPS-1:0][WIG_W-1:0]     rd_wig_o
);
  logic [GRP_W-1:0] grp_q [NUM_SETS];
  logic [WIG_W-1:0] wig_q [NUM_SETS][NUM_GROUPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        grp_q[s] <= '0;
        for (int g = 0; g < NUM_GROUPS; g++) wig_q[s][g] <= '0;
      end
    end else if (upd_valid_i) begin
      grp_q[upd_set_i]            <= upd_grp_i;
      wig_q[upd_set_i][upd_grp_i] <= upd_wig_i;
    end
  end

  always_comb begin
    rd_grp_o = grp_q[rd_set_i];
    for (int g = 0; g < NUM_GROUPS; g++) rd_wig_o[g] = wig_q[rd_set_i][g];
  end

  // R3
  upd_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> grp_q[$past(upd_set_i)] == $past(upd_grp_i));
  // R3
  upd_wig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> wig_q[$past(upd_set_i)][$past(upd_grp_i)] == $past(upd_wig_i));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_iso
    // R8
    other_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(upd_valid_i && upd_set_i == SET_W'(s)) |=> $stable(grp_q[s]));
  end
endmodule

// File: rtl/hnmru_pick.sv
module hnmru_pick #(
  parameter int NUM_WAYS   = 16,
  parameter int NUM_GROUPS = 2,
  parameter int LFSR_W     = 16,
  parameter int WAY_W      = 4,
  parameter int GRP_W      = 1,
  parameter int WIG_W      = 3
) (
  input  logic [NUM_WAYS-1:0]              valid_i,
  input  logic [GRP_W-1:0]                 mru_grp_i,
  input  logic [NUM_GROUPS-1:0][WIG_W-1:0] mru_wig_i,
  input  logic [LFSR_W-1:0]                rnd_i,
  output logic [WAY_W-1:0]                 way_o
);
  localparam int WPG      = NUM_WAYS / NUM_GROUPS;
  localparam int GRP_CAND = NUM_GROUPS - 1;
  localparam int WIG_CAND = WPG - 1;
  localparam int RND_W    = LFSR_W / 2;

  logic             any_inv;
  logic [WAY_W-1:0] inv_way;
  logic [31:0]      grp_k, wig_k;
  logic [GRP_W-1:0] vic_grp;
  logic [WIG_W-1:0] vic_wig;

  always_comb begin
    any_inv = ~&valid_i;
    inv_way = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) inv_way = WAY_W'(i);
    end
    // pick k-th eligible candidate, stepping over the MRU entry
    grp_k   = 32'(rnd_i[LFSR_W-1:RND_W]) % GRP_CAND;
    vic_grp = (GRP_W'(grp_k) < mru_grp_i) ? GRP_W'(grp_k) : GRP_W'(grp_k + 1);
    wig_k   = 32'(rnd_i[RND_W-1:0]) % WIG_CAND;
    vic_wig = (WIG_W'(wig_k) < mru_wig_i[vic_grp]) ? WIG_W'(wig_k) : WIG_W'(wig_k + 1);
    way_o   = any_inv ? inv_way : {vic_grp, vic_wig};
  end
endmodule

// File: rtl/hnmru_repl_sel.sv
module hnmru_repl_sel
  import hnmru_pkg::*;
#(
  parameter  int NUM_SETS   = 4,
  parameter  int NUM_WAYS   = 16,   // power of two
  parameter  int NUM_GROUPS = 2,    // power of two, >= 2, with >= 2 ways per group
  parameter  int LFSR_W     = 16,
  localparam int SET_W      = clog2_min1(NUM_SETS),
  localparam int WAY_W      = clog2_min1(NUM_WAYS),
  localparam int WPG        = NUM_WAYS / NUM_GROUPS,
  localparam int GRP_W      = clog2_min1(NUM_GROUPS),
  localparam int WIG_W      = clog2_min1(WPG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_valid_i,
  input  logic [SET_W-1:0]    upd_set_i,
  input  logic [WAY_W-1:0]    upd_way_i,
  input  logic [SET_W-1:0]    qry_set_i,
  input  logic [NUM_WAYS-1:0] qry_valid_i,
  output logic [WAY_W-1:0]    victim_way_o
);
  logic [LFSR_W-1:0]               rnd;
  logic [GRP_W-1:0]                rd_grp;
  logic [NUM_GROUPS-1:0][WIG_W-1:0] rd_wig;
  logic [NUM_WAYS-1:0]             low_mask;
  logic [GRP_W-1:0]                v_grp;
  logic [WIG_W-1:0]                v_wig;

  hnmru_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  hnmru_mru_state #(
    .NUM_SETS(NUM_SETS), .NUM_GROUPS(NUM_GROUPS),
    .SET_W(SET_W), .GRP_W(GRP_W), .WIG_W(WIG_W)
  ) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_valid_i(upd_valid_i),
    .upd_set_i  (upd_set_i),
    .upd_grp_i  (upd_way_i[WAY_W-1:WIG_W]),
    .upd_wig_i  (upd_way_i[WIG_W-1:0]),
    .rd_set_i   (qry_set_i),
    .rd_grp_o   (rd_grp),
    .rd_wig_o   (rd_wig)
  );

  hnmru_pick #(
    .NUM_WAYS(NUM_WAYS), .NUM_GROUPS(NUM_GROUPS), .LFSR_W(LFSR_W),
    .WAY_W(WAY_W), .GRP_W(GRP_W), .WIG_W(WIG_W)
  ) u_pick (
    .valid_i  (qry_valid_i),
    .mru_grp_i(rd_grp),
    .mru_wig_i(rd_wig),
    .rnd_i    (rnd),
    .way_o    (victim_way_o)
  );

  assign v_grp    = victim_way_o[WAY_W-1:WIG_W];
  assign v_wig    = victim_way_o[WIG_W-1:0];
  assign low_mask = (NUM_WAYS'(1) << victim_way_o) - NUM_WAYS'(1);

  // R4
  not_mru_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&qry_valid_i) |-> v_grp != rd_grp);
  // R5
  not_mru_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&qry_valid_i) |-> v_wig != rd_wig[v_grp]);
  // R6
  inv_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_valid_i != '1) |-> !qry_valid_i[victim_way_o]);
  // R6
  inv_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_valid_i != '1) |-> ((~qry_valid_i & low_mask) == '0));
endmodule

// File: tb/hnmru_repl_sel_tb.sv
`timescale 1ns/1ps
module hnmru_repl_sel_tb;
  localparam int NS = 4, NW = 16, NG = 2, WPG = 8;

  logic        clk = 0, rst_n = 0;
  logic        upd_valid = 0;
  logic [1:0]  upd_set = 0, qry_set = 0;
  logic [3:0]  upd_way = 0;
  logic [15:0] qry_valid = '1;
  logic [3:0]  victim;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_grp [NS];
  int m_wig [NS][NG];

  always #2 clk = ~clk;

  hnmru_repl_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(upd_valid), .upd_set_i(upd_set),
    .upd_way_i(upd_way), .qry_set_i(qry_set), .qry_valid_i(qry_valid),
    .victim_way_o(victim)
  );

  function automatic logic [15:0] elig_mask(int s);
    logic [15:0] m = '0;
    for (int v = 0; v < NW; v++)
      if ((v / WPG) != m_grp[s] && (v % WPG) != m_wig[s][v / WPG]) m[v] = 1'b1;
    return m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_upd(int s, int w);
    m_grp[s] = w / WPG;
    m_wig[s][w / WPG] = w % WPG;
  endtask

  task automatic do_upd(int s, int w);
    @(negedge clk);
    upd_valid = 1; upd_set = 2'(s); upd_way = 4'(w);
    @(posedge clk); #1;
    upd_valid = 0;
    model_upd(s, w);
  endtask

  // all-valid query; returns victim
  task automatic q_all(int s, string req, output int v);
    logic [15:0] m;
    @(negedge clk);
    qry_set = 2'(s); qry_valid = '1;
    #1;
    v = int'(victim);
    m = elig_mask(s);
    chk(m[v], req, v, int'(m));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    logic [15:0] seen, vm;
    for (int s = 0; s < NS; s++) begin
      m_grp[s] = 0;
      for (int g = 0; g < NG; g++) m_wig[s][g] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R2: reset pointers zero -> victims in ways 9..15
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 20; k++) begin
        q_all(s, "R2", v);
        chk(v >= 9 && v <= 15, "R2 range", v, 9);
      end

    // R1 R3 R4 R5 R7 R8: sweep every way as the older MRU of the non-MRU group
    for (int s = 0; s < NS; s++)
      for (int a = 0; a < NW; a++) begin
        int b;
        b = ((a / WPG == 0) ? WPG : 0) + ((a + 3) % WPG);
        do_upd(s, a);
        do_upd(s, b);
        seen = '0;
        for (int k = 0; k < 200; k++) begin
          q_all(s, "R3 R4 R5", v);
          seen[v] = 1'b1;
        end
        chk(seen == elig_mask(s), "R1 R7 coverage", int'(seen), int'(elig_mask(s)));
        for (int k = 0; k < 4; k++) q_all((s + 1) % NS, "R8", v);
      end

    // R9: same-cycle update and query to one set
    for (int w = 0; w < NW; w++) begin
      logic [15:0] m_old, m_new;
      do_upd(2, (w + WPG) % NW);
      m_old = elig_mask(2);
      @(negedge clk);
      upd_valid = 1; upd_set = 2'd2; upd_way = 4'(w);
      qry_set = 2'd2; qry_valid = '1;
      #1;
      chk(m_old[victim], "R9 old state", int'(victim), int'(m_old));
      @(posedge clk); #1;
      upd_valid = 0;
      model_upd(2, w);
      m_new = elig_mask(2);
      @(negedge clk); #1;
      chk(m_new[victim], "R9 new state", int'(victim), int'(m_new));
    end

    // R6: lowest invalid way wins, even when it is the MRU way
    for (int i = 0; i < NW; i++) begin
      int j, e;
      j = (i + 5) % NW;
      e = (i < j) ? i : j;
      do_upd(0, i);
      @(negedge clk);
      qry_set = 2'd0;
      vm = '1; vm[i] = 1'b0; vm[j] = 1'b0;
      qry_valid = vm;
      #1;
      chk(int'(victim) == e, "R6", int'(victim), e);
    end
    @(negedge clk);
    qry_valid = '0; qry_set = 2'd1;
    #1;
    chk(victim == 4'd0, "R6 all invalid", int'(victim), 0);
    @(negedge clk);
    qry_valid = '1;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule